// File: doc/BRIEF.md
# Bit-serial receive frame-check-sequence verifier

This block checks the 16-bit frame check sequence of a bit-oriented HDLC/SDLC receive frame. An upstream framer, which finds the flags and strips the stuffed zeros, presents one destuffed bit per strobe. The framer also reports hunt mode, every flag it sees, and a separate pulse for the closing flag. The verifier feeds every strobed bit between the opening and closing flags into a CRC remainder. The remainder uses the polynomial x^16 + x^12 + x^5 + 1. No enable input exists, so checking is always on.

The transmitter sends the complement of its CRC. A clean frame therefore does not leave a zero remainder. It leaves the fixed pattern 16'h1D0F. When the closing flag arrives, the verifier compares the remainder with that pattern and latches the result as an error flag. It also pulses a frame-done strobe. The error flag means something only in the cycle that frame_done is high.

The remainder is preset whenever the receiver hunts, whenever any flag is seen, and on a software command. A control input chooses whether the preset value is all ones or all zeros. The running remainder is also brought out for debug.

Top module: `sdlc_rx_crc_chk`

## Requirements
- R1: While rst_n is low, remainder reads 16'hFFFF and both crc_err and frame_done read 0.
- R2: Each clock edge with rx_valid high and no preset folds rx_bit into the remainder as follows. First compute fb = remainder[15] ^ rx_bit. Then the next remainder is (remainder << 1), XORed with 16'h1021 when fb is 1. The result is visible in the following cycle.
- R3: On an edge with rx_valid low and no preset, the remainder keeps its value.
- R4: An edge with any of hunt, flag_seen, close_flag or sw_preset high loads the remainder with a preset value. The value is 16'hFFFF when preset_ones is 1 and 16'h0000 when it is 0.
- R5: A preset takes priority over a valid bit in the same cycle. That bit is discarded.
- R6: An edge with close_flag high does two things. It latches crc_err = (remainder != 16'h1D0F), using the remainder held before that edge. It also raises frame_done for exactly the next cycle. At all other times frame_done is 0.
- R7: crc_err keeps its value from one closing flag to the next. Bits, presets and hunt mode in between do not change it.
- R8: A frame is followed by its FCS, sent as ~r[15] first down to ~r[0]. Here r is the bench's R2 remainder over the data, started from the selected preset. Such a frame gives crc_err = 0 for either preset polarity, while any single flipped bit gives crc_err = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Destuffed receive bit |
| rx_valid | input | 1 | rx_bit is a real frame bit this cycle |
| hunt | input | 1 | Receiver is searching for a flag |
| flag_seen | input | 1 | Pulse: any flag recognised |
| close_flag | input | 1 | Pulse: closing flag of a frame recognised |
| preset_ones | input | 1 | 1 = preset to all ones, 0 = preset to all zeros |
| sw_preset | input | 1 | Software preset command |
| crc_err | output | 1 | Latched FCS error of the last frame |
| frame_done | output | 1 | One-cycle pulse: crc_err is valid |
| remainder | output | 16 | Running CRC remainder for debug |

## Verification
Two collisions matter here. A preset can land in the same cycle as a valid bit. A closing flag can coincide with a bit that the framer still strobes. In both cases the bench drives the two inputs high in one cycle. A per-clock behavioural model then judges the result: the bit must be discarded, the preset value must appear, and the verdict must use the remainder from before that edge. Whole frames with good and single-bit-corrupted FCS, built by an independent generator in the bench, are sent in both preset polarities and with idle gaps in the bit stream.

// File: rtl/sdlc_crc_pkg.sv
package sdlc_crc_pkg;
  localparam int CRC_W = 16;

  typedef logic [CRC_W-1:0] crc_t;

  // one bit of an LSB-first (reflected) CRC step
  function automatic crc_t crc_fold_refl(input crc_t c, input logic b, input crc_t poly_refl);
    crc_t nxt;
    logic fb;
    fb  = c[0] ^ b;
    nxt = c >> 1;
    if (fb) nxt = nxt ^ poly_refl;
    return nxt;
  endfunction

  // mirror the bit order of a CRC word
  function automatic crc_t bit_rev(input crc_t v);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_preset_ctl.sv
module crc_preset_ctl
  import sdlc_crc_pkg::*;
(
  input  logic hunt,
  input  logic flag_seen,
  input  logic close_flag,
  input  logic sw_preset,
  input  logic preset_ones,
  output logic preset_evt,
  output crc_t preset_val
);
  localparam crc_t ALL_ONES = {CRC_W{1'b1}};

  always_comb begin
    preset_evt = hunt | flag_seen | close_flag | sw_preset;
    preset_val = preset_ones ? ALL_ONES : '0;
  end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg
  import sdlc_crc_pkg::*;
#(
  parameter crc_t POLY_REFL = 16'h8408
)(
  input  logic clk,
  input  logic rst_n,
  input  logic preset_evt,
  input  crc_t preset_val,
  input  logic bit_valid,
  input  logic bit_in,
  output crc_t crc_refl
);
  localparam crc_t RST_VAL = {CRC_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_refl <= RST_VAL;
    else if (preset_evt) crc_refl <= preset_val;
    else if (bit_valid)  crc_refl <= crc_fold_refl(crc_refl, bit_in, POLY_REFL);
  end

  // R4 R5
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_evt |=> crc_refl == $past(preset_val));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_evt && !bit_valid) |=> $stable(crc_refl));
endmodule

// File: rtl/crc_frame_judge.sv
module crc_frame_judge
  import sdlc_crc_pkg::*;
#(
  parameter crc_t GOOD_RES = 16'h1D0F
)(
  input  logic clk,
  input  logic rst_n,
  input  logic close_flag,
  input  crc_t remainder,
  output logic crc_err,
  output logic frame_done
);
  logic mismatch;
  assign mismatch = (remainder != GOOD_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= close_flag;
      if (close_flag) crc_err <= mismatch;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_flag |=> frame_done);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !close_flag |=> !frame_done);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !close_flag |=> $stable(crc_err));
endmodule

// File: rtl/sdlc_rx_crc_chk.sv
module sdlc_rx_crc_chk
  import sdlc_crc_pkg::*;
#(
  parameter logic [15:0] POLY_REFL = 16'h8408,
  parameter logic [15:0] GOOD_RES  = 16'h1D0F
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_bit,
  input  logic        rx_valid,
  input  logic        hunt,
  input  logic        flag_seen,
  input  logic        close_flag,
  input  logic        preset_ones,
  input  logic        sw_preset,
  output logic        crc_err,
  output logic        frame_done,
  output logic [15:0] remainder
);
  logic preset_evt;
  crc_t preset_val;
  crc_t crc_refl;

  crc_preset_ctl u_preset (
    .hunt       (hunt),
    .flag_seen  (flag_seen),
    .close_flag (close_flag),
    .sw_preset  (sw_preset),
    .preset_ones(preset_ones),
    .preset_evt (preset_evt),
    .preset_val (preset_val)
  );

  crc_shift_reg #(.POLY_REFL(POLY_REFL)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset_evt(preset_evt),
    .preset_val(preset_val),
    .bit_valid (rx_valid),
    .bit_in    (rx_bit),
    .crc_refl  (crc_refl)
  );

  // MSB-first view of the reflected register
  assign remainder = bit_rev(crc_refl);

  crc_frame_judge #(.GOOD_RES(GOOD_RES)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_flag(close_flag),
    .remainder (remainder),
    .crc_err   (crc_err),
    .frame_done(frame_done)
  );

  // R6
  good_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_flag && remainder == GOOD_RES) |=> !crc_err);

  // R4
  hunt_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && !preset_ones) |=> remainder == 16'h0000);
endmodule

// File: tb/sim_sdlc_rx_crc_chk.sv
module sim_sdlc_rx_crc_chk;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, rx_bit = 1'b0, rx_valid = 1'b0, hunt = 1'b1;
  logic flag_seen = 1'b0, close_flag = 1'b0, preset_ones = 1'b1, sw_preset = 1'b0;
  logic crc_err, frame_done;
  logic [15:0] remainder;

  int total = 0, bad = 0;
  bit finished = 0;

  sdlc_rx_crc_chk u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .hunt(hunt), .flag_seen(flag_seen), .close_flag(close_flag),
    .preset_ones(preset_ones), .sw_preset(sw_preset),
    .crc_err(crc_err), .frame_done(frame_done), .remainder(remainder)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] r, input logic b);
    logic [15:0] n;
    n = {r[14:0], 1'b0};
    if (r[15] ^ b) n = n ^ 16'h1021;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, updated from stable inputs at each edge
  logic [15:0] m_rem = 16'hFFFF;
  logic m_err = 1'b0, m_done = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem <= 16'hFFFF; m_err <= 1'b0; m_done <= 1'b0;
    end else begin
      m_done <= close_flag;
      if (close_flag) m_err <= (m_rem != 16'h1D0F);
      if (hunt || flag_seen || close_flag || sw_preset) m_rem <= preset_ones ? 16'hFFFF : 16'h0000;
      else if (rx_valid) m_rem <= ref_step(m_rem, rx_bit);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(remainder == m_rem, "R2 R3 R4 R5 remainder", remainder, m_rem);
      chk(crc_err == m_err, "R6 R7 crc_err", {15'd0, crc_err}, {15'd0, m_err});
      chk(frame_done == m_done, "R6 frame_done", {15'd0, frame_done}, {15'd0, m_done});
    end
  end

  task automatic send_frame(input logic pones, input int nbytes, input int seed,
                            input int flip, input int gap_every);
    logic [15:0] r;
    bit q[$];
    logic [7:0] d;
    preset_ones = pones;
    r = pones ? 16'hFFFF : 16'h0000;
    for (int i = 0; i < nbytes; i++) begin
      d = 8'((seed * 37 + i * 91 + 5) & 255);
      for (int k = 0; k < 8; k++) begin
        q.push_back(d[k]);
        r = ref_step(r, d[k]);
      end
    end
    for (int k = 15; k >= 0; k--) q.push_back(~r[k]);
    if (flip >= 0) q[flip] = ~q[flip];
    flag_seen = 1'b1; @(negedge clk); flag_seen = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      rx_bit = q[i]; rx_valid = 1'b1; @(negedge clk);
      if (gap_every > 0 && (i % gap_every) == 0) begin
        rx_valid = 1'b0; rx_bit = ~rx_bit; @(negedge clk);
      end
    end
    rx_valid = 1'b0; close_flag = 1'b1; @(negedge clk); close_flag = 1'b0;
    chk(frame_done == 1'b1, "R6 frame_done after close", {15'd0, frame_done}, 16'd1);
    chk(crc_err == (flip >= 0), "R8 crc_err verdict", {15'd0, crc_err}, {15'd0, flip >= 0});
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(remainder == 16'hFFFF, "R1 reset remainder", remainder, 16'hFFFF);
    chk(crc_err == 1'b0, "R1 reset crc_err", {15'd0, crc_err}, 16'd0);
    chk(frame_done == 1'b0, "R1 reset frame_done", {15'd0, frame_done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk); hunt = 1'b0; @(negedge clk);

    // R8 good frames, both preset polarities, with and without gaps
    send_frame(1'b1, 4, 1, -1, 0);
    send_frame(1'b0, 6, 2, -1, 0);
    send_frame(1'b1, 5, 3, -1, 3);
    send_frame(1'b0, 3, 4, -1, 5);
    // R8 single-bit errors in data and in FCS
    send_frame(1'b1, 4, 5, 0, 0);
    send_frame(1'b1, 4, 6, 17, 2);
    send_frame(1'b0, 4, 7, 40, 0);
    send_frame(1'b1, 2, 8, 31, 0);

    // R7 verdict holds across traffic, presets and hunt
    rx_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin rx_bit = i[0]; @(negedge clk); end
    rx_valid = 1'b0; sw_preset = 1'b1; @(negedge clk); sw_preset = 1'b0;
    hunt = 1'b1; @(negedge clk); hunt = 1'b0; @(negedge clk);
    chk(crc_err == 1'b1, "R7 crc_err held", {15'd0, crc_err}, 16'd1);
    chk(frame_done == 1'b0, "R7 frame_done quiet", {15'd0, frame_done}, 16'd0);

    // R5 software preset collides with a valid bit
    preset_ones = 1'b1;
    rx_valid = 1'b1; rx_bit = 1'b1; @(negedge clk);
    sw_preset = 1'b1; rx_bit = 1'b1; @(negedge clk);
    sw_preset = 1'b0; rx_valid = 1'b0;
    chk(remainder == 16'hFFFF, "R5 preset beats bit", remainder, 16'hFFFF);

    // R4 hunt with zero preset mid-frame
    preset_ones = 1'b0;
    rx_valid = 1'b1;
    for (int i = 0; i < 7; i++) begin rx_bit = ~i[1]; @(negedge clk); end
    rx_valid = 1'b0; hunt = 1'b1; @(negedge clk); hunt = 1'b0;
    chk(remainder == 16'h0000, "R4 hunt zero preset", remainder, 16'h0000);
    @(negedge clk);
    chk(remainder == 16'h0000, "R3 idle hold", remainder, 16'h0000);

    // R6 closing flag coincides with a valid bit: old remainder judged
    preset_ones = 1'b1;
    send_frame(1'b1, 3, 9, -1, 0);
    preset_ones = 1'b1;
    flag_seen = 1'b1; @(negedge clk); flag_seen = 1'b0;
    rx_valid = 1'b1; rx_bit = 1'b0; close_flag = 1'b1; @(negedge clk);
    close_flag = 1'b0; rx_valid = 1'b0;
    chk(crc_err == 1'b1, "R6 verdict on preset remainder", {15'd0, crc_err}, 16'd1);
    chk(remainder == 16'hFFFF, "R5 close discards bit", remainder, 16'hFFFF);

    // R2 single step from all ones with a 0 bit
    rx_valid = 1'b1; rx_bit = 1'b0; @(negedge clk); rx_valid = 1'b0;
    chk(remainder == ref_step(16'hFFFF, 1'b0), "R2 single fold", remainder, ref_step(16'hFFFF, 1'b0));

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule